// File: doc/BRIEF.md
# UART Channel Mode Register Bank

This block holds the character-format and operating-mode configuration for a set of UART channels. Each channel owns two 8-bit mode registers that answer at one shared bus address. A per-channel selector decides which of the two a bus access reaches. After reset the selector points at the first register. Any read or write there moves it to the second register, where it stays until the channel's command logic pulses a selector-clear strobe.

The CPU side is a plain strobe interface with an address, a read strobe, a write strobe and 8-bit data buses. Read data is combinational in the strobe cycle. The configuration side presents the stored fields already decoded, per channel, as flat vectors: channel `c` occupies bit `c` of the 1-bit fields, bits `2c+1:2c` of the 2-bit fields and bits `4c+3:4c` of the character length. Transmitters and receivers wire directly to these vectors.

Top module: `uart_mode_bank`

## Requirements
- R1: After reset every channel's selector points at the first mode register and both registers read 0. The decoded outputs show 5 data bits, parity mode code 00, channel mode 00 and all 1-bit fields low.
- R2: A read or write accepted while a channel's selector is at the first register targets the first register. From the next clock edge the selector points at the second register.
- R3: While the selector is at the second register, all later reads and writes target the second register and leave the selector there.
- R4: A pulse on `ptr_clr[c]` returns channel `c`'s selector to the first register at the next edge. If a bus access to that channel falls in the same cycle, the access still targets the register selected before the edge, and the selector ends at the first register.
- R5: While `rd_stb` is high and the address matches a channel, `rdata` shows that channel's currently selected register in the same cycle. Otherwise `rdata` is 0.
- R6: Channel `c` answers at address `c*CH_STRIDE` (0 and 8 by default). Accesses to any other address change no register and no selector.
- R7: First register fields are decoded as follows:
  - bit 7 drives `cfg_rts_ctl`
  - bit 6 drives `cfg_rxint_sel`
  - bit 5 drives `cfg_err_block`
  - bits 4:3 drive `cfg_par_mode`
  - bit 2 drives `cfg_par_type`
- R8: First register bits 1:0 with codes 00, 01, 10 and 11 give `cfg_char_bits` values of 5, 6, 7 and 8.
- R9: `cfg_multidrop` is high exactly when parity mode code is 11. In that case `cfg_par_type` gives the address/data bit polarity.
- R10: Second register bits 7:6 drive `cfg_chan_mode`: 00 normal, 01 automatic echo, 10 local loopback, 11 remote loopback. All 8 bits of the second register read back as written.
- R11: Each channel's selector and registers are independent: an access or selector clear on one channel leaves every other channel's state and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Bus address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| ptr_clr | input | NUM_CH | Per-channel selector clear from command logic |
| cfg_rts_ctl | output | NUM_CH | Receiver RTS flow-control enable |
| cfg_rxint_sel | output | NUM_CH | Receiver interrupt source select |
| cfg_err_block | output | NUM_CH | Accumulated (block) error status mode |
| cfg_par_mode | output | 2*NUM_CH | Parity mode code |
| cfg_par_type | output | NUM_CH | Parity type / forced polarity / address-data polarity |
| cfg_char_bits | output | 4*NUM_CH | Data bits per character, 5 to 8 |
| cfg_multidrop | output | NUM_CH | Multidrop mode active |
| cfg_chan_mode | output | 2*NUM_CH | Channel operating mode |

## Verification
Read data is due in the strobe cycle itself, so the bench raises `rd_stb` on a falling edge and samples `rdata` a moment later, before the next rising edge. The selector move, register writes and decoded fields all settle on the rising edge that ends the strobe cycle. The bench therefore checks them at the following falling edge, one cycle after the stimulus. Every first-register value is swept on both channels, and the other channel's outputs are checked after each access.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;

   localparam int unsigned REG_W = 8;

   typedef enum logic {
      SEL_FIRST  = 1'b0,
      SEL_SECOND = 1'b1
   } mr_sel_e;

   typedef enum logic [1:0] {
      PAR_ON    = 2'b00,
      PAR_FORCE = 2'b01,
      PAR_OFF   = 2'b10,
      PAR_MDROP = 2'b11
   } par_mode_e;

   typedef enum logic [1:0] {
      CM_NORMAL = 2'b00,
      CM_ECHO   = 2'b01,
      CM_LLOOP  = 2'b10,
      CM_RLOOP  = 2'b11
   } chan_mode_e;

   typedef struct packed {
      logic       rts_ctl;
      logic       rxint_sel;
      logic       err_block;
      par_mode_e  par_mode;
      logic       par_type;
      logic [3:0] char_bits;
      logic       multidrop;
      chan_mode_e chan_mode;
   } mode_cfg_t;

   function automatic logic [3:0] len_from_code(input logic [1:0] code);
      return 4'd5 + {2'b00, code};
   endfunction

endpackage

// File: rtl/mode_ptr.sv
module mode_ptr
   import uart_mode_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    access,
   input  logic    clr,
   output mr_sel_e sel
);

   mr_sel_e sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= SEL_FIRST;
      else if (clr)
         sel_q <= SEL_FIRST;
      else if (access)
         sel_q <= SEL_SECOND;
   end

   assign sel = sel_q;

   // R2: access without clear leaves the selector at the second register
   a_r2_advance : assert property (@(posedge clk) disable iff (!rst_n)
      (access && !clr) |=> (sel == SEL_SECOND));

   // R3: second register is sticky until cleared
   a_r3_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_SECOND && !clr) |=> (sel == SEL_SECOND));

   // R4: a clear always wins
   a_r4_clear_wins : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sel == SEL_FIRST));

endmodule

// File: rtl/mode_regs.sv
module mode_regs
   import uart_mode_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  mr_sel_e           sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mr_first,
   output logic [DATA_W-1:0] mr_second
);

   if (DATA_W != REG_W) begin : g_bad_width
      $error("mode_regs: DATA_W must equal %0d", REG_W);
   end

   logic [DATA_W-1:0] first_q, second_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q  <= '0;
         second_q <= '0;
      end else if (wr) begin
         if (sel == SEL_FIRST)
            first_q  <= wdata;
         else
            second_q <= wdata;
      end
   end

   assign mr_first  = first_q;
   assign mr_second = second_q;

   // R2: a write while pointing at the first register lands there only
   a_r2_first_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_FIRST) |=> (mr_first == $past(wdata)) && $stable(mr_second));

   // R3: a write while pointing at the second register lands there only
   a_r3_second_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_SECOND) |=> (mr_second == $past(wdata)) && $stable(mr_first));

   // R11: without a write this channel's storage holds
   a_r11_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(mr_first) && $stable(mr_second));

endmodule

// File: rtl/mode_decode.sv
module mode_decode
   import uart_mode_pkg::*;
(
   input  logic [7:0] mr_first,
   input  logic [1:0] mode_bits,
   output mode_cfg_t  cfg
);

   always_comb begin
      cfg.rts_ctl   = mr_first[7];
      cfg.rxint_sel = mr_first[6];
      cfg.err_block = mr_first[5];
      cfg.par_mode  = par_mode_e'(mr_first[4:3]);
      cfg.par_type  = mr_first[2];
      cfg.char_bits = len_from_code(mr_first[1:0]);
      cfg.multidrop = (mr_first[4:3] == PAR_MDROP);
      cfg.chan_mode = chan_mode_e'(mode_bits);
   end

   // R8: length always within 5..8
   always_comb begin
      a_r8_len_range : assert (cfg.char_bits >= 4'd5 && cfg.char_bits <= 4'd8);
   end

endmodule

// File: rtl/mode_channel.sv
module mode_channel
   import uart_mode_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic              clr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_val,
   output mode_cfg_t         cfg
);

   mr_sel_e           sel;
   logic [DATA_W-1:0] mr_first, mr_second;
   logic              acc, wr_en;

   assign acc   = hit && (rd_stb || wr_stb);
   assign wr_en = hit && wr_stb;

   mode_ptr u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .access (acc),
      .clr    (clr),
      .sel    (sel)
   );

   mode_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_en),
      .sel       (sel),
      .wdata     (wdata),
      .mr_first  (mr_first),
      .mr_second (mr_second)
   );

   mode_decode u_dec (
      .mr_first  (mr_first),
      .mode_bits (mr_second[7:6]),
      .cfg       (cfg)
   );

   always_comb begin
      if (hit && rd_stb)
         rd_val = (sel == SEL_FIRST) ? mr_first : mr_second;
      else
         rd_val = '0;
   end

endmodule

// File: rtl/uart_mode_bank.sv
module uart_mode_bank
   import uart_mode_pkg::*;
#(
   parameter int unsigned NUM_CH    = 2,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CH_STRIDE = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                rd_stb,
   input  logic                wr_stb,
   input  logic [7:0]          wdata,
   output logic [7:0]          rdata,
   input  logic [NUM_CH-1:0]   ptr_clr,
   output logic [NUM_CH-1:0]   cfg_rts_ctl,
   output logic [NUM_CH-1:0]   cfg_rxint_sel,
   output logic [NUM_CH-1:0]   cfg_err_block,
   output logic [2*NUM_CH-1:0] cfg_par_mode,
   output logic [NUM_CH-1:0]   cfg_par_type,
   output logic [4*NUM_CH-1:0] cfg_char_bits,
   output logic [NUM_CH-1:0]   cfg_multidrop,
   output logic [2*NUM_CH-1:0] cfg_chan_mode
);

   localparam int unsigned SPAN = NUM_CH * CH_STRIDE;

   if (NUM_CH < 1) begin : g_bad_nch
      $error("uart_mode_bank: NUM_CH must be at least 1");
   end
   if (CH_STRIDE < 1 || SPAN > (1 << ADDR_W)) begin : g_bad_map
      $error("uart_mode_bank: channel map does not fit the address space");
   end

   logic [NUM_CH-1:0] hit;
   logic [7:0]        rd_each [NUM_CH];
   mode_cfg_t         cfg_each [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * CH_STRIDE);

      assign hit[c] = (addr == BASE);

      mode_channel #(.DATA_W(8)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .hit    (hit[c]),
         .rd_stb (rd_stb),
         .wr_stb (wr_stb),
         .clr    (ptr_clr[c]),
         .wdata  (wdata),
         .rd_val (rd_each[c]),
         .cfg    (cfg_each[c])
      );

      assign cfg_rts_ctl[c]       = cfg_each[c].rts_ctl;
      assign cfg_rxint_sel[c]     = cfg_each[c].rxint_sel;
      assign cfg_err_block[c]     = cfg_each[c].err_block;
      assign cfg_par_mode[2*c+:2] = cfg_each[c].par_mode;
      assign cfg_par_type[c]      = cfg_each[c].par_type;
      assign cfg_char_bits[4*c+:4]= cfg_each[c].char_bits;
      assign cfg_multidrop[c]     = cfg_each[c].multidrop;
      assign cfg_chan_mode[2*c+:2]= cfg_each[c].chan_mode;
   end

   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CH; c++)
         rdata = rdata | rd_each[c];
   end

   // R5: no read strobe means quiet read bus
   a_r5_idle_bus : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> (rdata == 8'h00));

   // R6: one address never reaches two channels
   a_r6_single_hit : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   // R1: decoded length after reset is the minimum
   a_r1_reset_len : assert property (@(posedge clk)
      $rose(rst_n) |-> (cfg_char_bits[3:0] == 4'd5));

endmodule

// File: tb/uart_mode_bank_tb.sv
module uart_mode_bank_tb;

   localparam int NCH = 2;
   localparam int STRIDE = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [3:0]     addr = '0;
   logic           rd_stb = 1'b0, wr_stb = 1'b0;
   logic [7:0]     wdata = '0;
   logic [7:0]     rdata;
   logic [NCH-1:0] ptr_clr = '0;
   logic [NCH-1:0] cfg_rts_ctl, cfg_rxint_sel, cfg_err_block, cfg_par_type, cfg_multidrop;
   logic [2*NCH-1:0] cfg_par_mode, cfg_chan_mode;
   logic [4*NCH-1:0] cfg_char_bits;

   int checks = 0, failures = 0;
   logic [7:0] m1 [NCH];
   logic [7:0] m2 [NCH];
   bit         p2 [NCH];

   always #2.5 clk = ~clk;

   uart_mode_bank u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .wdata(wdata), .rdata(rdata), .ptr_clr(ptr_clr),
      .cfg_rts_ctl(cfg_rts_ctl), .cfg_rxint_sel(cfg_rxint_sel),
      .cfg_err_block(cfg_err_block), .cfg_par_mode(cfg_par_mode),
      .cfg_par_type(cfg_par_type), .cfg_char_bits(cfg_char_bits),
      .cfg_multidrop(cfg_multidrop), .cfg_chan_mode(cfg_chan_mode)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int chan_of(input int a);
      for (int c = 0; c < NCH; c++) if (a == c * STRIDE) return c;
      return -1;
   endfunction

   // decoded outputs of one channel versus the model (R7, R8, R9, R10)
   task automatic check_cfg(input int c);
      logic [7:0] v = m1[c];
      check("R7 rts",    cfg_rts_ctl[c],   v[7]);
      check("R7 rxint",  cfg_rxint_sel[c], v[6]);
      check("R7 err",    cfg_err_block[c], v[5]);
      check("R7 parity", cfg_par_mode[2*c+:2], v[4:3]);
      check("R9 type",   cfg_par_type[c],  v[2]);
      check("R8 length", cfg_char_bits[4*c+:4], 5 + v[1:0]);
      check("R9 mdrop",  cfg_multidrop[c], (v[4:3] == 2'b11) ? 1 : 0);
      check("R10 mode",  cfg_chan_mode[2*c+:2], m2[c][7:6]);
   endtask

   task automatic bus_wr(input int a, input logic [7:0] d, input logic [NCH-1:0] clr = '0);
      int c = chan_of(a);
      @(negedge clk);
      addr = 4'(a); wdata = d; wr_stb = 1'b1; ptr_clr = clr;
      @(negedge clk);
      wr_stb = 1'b0; ptr_clr = '0;
      if (c >= 0) begin
         if (p2[c]) m2[c] = d; else m1[c] = d;
         p2[c] = 1'b1;
      end
      for (int k = 0; k < NCH; k++) if (clr[k]) p2[k] = 1'b0;
   endtask

   task automatic bus_rd(input int a, input string req);
      int c = chan_of(a);
      int exp;
      @(negedge clk);
      addr = 4'(a); rd_stb = 1'b1;
      #1;
      exp = (c < 0) ? 0 : (p2[c] ? m2[c] : m1[c]);
      check(req, rdata, exp);
      @(negedge clk);
      rd_stb = 1'b0;
      if (c >= 0) p2[c] = 1'b1;
   endtask

   task automatic clear(input int c);
      @(negedge clk);
      ptr_clr[c] = 1'b1;
      @(negedge clk);
      ptr_clr[c] = 1'b0;
      p2[c] = 1'b0;
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin m1[c] = '0; m2[c] = '0; p2[c] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int c = 0; c < NCH; c++) begin
         check("R1 len", cfg_char_bits[4*c+:4], 5);
         check("R1 mode", cfg_chan_mode[2*c+:2], 0);
         check_cfg(c);
      end
      check("R5 idle", rdata, 0);
      bus_rd(0, "R1 first reads zero");
      bus_rd(0, "R1 second reads zero");

      // R2/R3/R8/R9/R10/R11 sweep of all first-register values on each channel
      for (int c = 0; c < NCH; c++) begin
         for (int v = 0; v < 256; v++) begin
            clear(c);
            bus_wr(c * STRIDE, 8'(v));
            bus_wr(c * STRIDE, 8'(v) ^ 8'hA5);
            for (int k = 0; k < NCH; k++) check_cfg(k); // R11 other channel too
            if (v % 32 == 0) begin
               bus_rd(c * STRIDE, "R3 read second");
               clear(c);
               bus_rd(c * STRIDE, "R2 read first");
               bus_rd(c * STRIDE, "R3 read second sticky");
            end
         end
      end

      // R4: clear and write in the same cycle
      clear(0);
      bus_wr(0, 8'h3C);                 // pointer now at second
      bus_wr(0, 8'hC0, 2'b01);          // goes to second, pointer back to first
      check_cfg(0);
      bus_rd(0, "R4 clear wins, first selected");
      bus_rd(0, "R4 second holds collided write");
      bus_wr(0, 8'h81, 2'b01);          // pointer at second: second written, then cleared
      bus_rd(0, "R4 first after collision");

      // R6: unmapped addresses change nothing
      bus_wr(3, 8'hFF);
      bus_rd(5, "R6 unmapped read zero");
      for (int k = 0; k < NCH; k++) check_cfg(k);
      clear(1);
      bus_rd(STRIDE, "R6 selector unmoved");

      // R11: clearing one channel leaves the other selector alone
      bus_rd(0, "R11 ch0 pointer set");
      clear(1);
      bus_rd(0, "R11 ch0 still second");
      bus_rd(STRIDE, "R11 ch1 at first");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule